// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector

This block watches one serial data bit, sampled on every rising clock edge, and flags each time the three most recent accepted bits form the pattern one, zero, one. It is a four-state Moore machine. Its flag output is taken from a register, so the flag rises in the clock cycle after the edge that samples the completing one, and it stays high for exactly one cycle.

Detections never share bits. When a match completes, the final one is not reused as the first one of the next match. The stream 1,0,1,0,1 therefore gives a single flag after the third bit, and none after the fifth. A synchronous, active-high reset returns the machine to its idle state with the flag low.

Top module: `pat101_detector`

## Requirements
- R1: On a rising edge with `rst` high, the machine enters idle (code 00) and `match_out` is 0 in the following cycle, whatever `ser_in` is.
- R2: In idle (00), a sampled 1 moves to the seen-one state (01) and a sampled 0 stays in idle.
- R3: In seen-one (01), a sampled 0 moves to the seen-one-zero state (10) and a sampled 1 stays in seen-one.
- R4: In seen-one-zero (10), a sampled 1 moves to the matched state (11) and a sampled 0 returns to idle.
- R5: In matched (11), a sampled 1 moves to seen-one (01) and a sampled 0 returns to idle.
- R6: `match_out` is 1 exactly in the cycles where the machine is in the matched state (11). That is the cycle after the edge that samples the completing 1.
- R7: Detections do not overlap. The stream 1,0,1,0,1 from idle raises `match_out` after the third bit only.
- R8: `match_out` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `ser_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data bit |
| match_out | output | 1 | Registered detect flag, high for one cycle per match |

## Verification
The input patterns are run as one continuous stream:
- Repeated 1,0,1 with a trailing 0,1 separates non-overlapping detection from overlapping detection.
- A 1 that arrives right after a match must act as a fresh first bit. The stream 1,0,1,1,0,1 therefore gives two flags.
- Runs of ones and runs of zeros show that seen-one holds on a 1, and that seen-one-zero drops back to idle on a 0.
- Resets applied in the middle of a partial match, and while a match is flagged, show that no partial progress survives a reset.

// File: rtl/pat101_pkg.sv
package pat101_pkg;

    localparam int unsigned STATE_W = 2;

    // Encoding is fixed: the flag decode and the checks rely on these codes.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'b00,
        ST_ONE    = 2'b01,
        ST_ONEZ   = 2'b10,
        ST_MATCH  = 2'b11
    } det_state_e;

    typedef struct packed {
        det_state_e state;
        logic       flag;
    } det_regs_t;

endpackage

// File: rtl/pat101_next.sv
module pat101_next
    import pat101_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       bit_in,
    output det_state_e nxt_state
);

    always_comb begin
        nxt_state = ST_IDLE;
        unique case (cur_state)
            ST_IDLE:  nxt_state = bit_in ? ST_ONE   : ST_IDLE;
            ST_ONE:   nxt_state = bit_in ? ST_ONE   : ST_ONEZ;
            ST_ONEZ:  nxt_state = bit_in ? ST_MATCH : ST_IDLE;
            // Matched: the completing 1 is not reused; a new 1 starts afresh.
            ST_MATCH: nxt_state = bit_in ? ST_ONE   : ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pat101_flag.sv
module pat101_flag
    import pat101_pkg::*;
(
    input  det_state_e state_in,
    output logic       flag_out
);

    assign flag_out = (state_in == ST_MATCH);

endmodule

// File: rtl/pat101_detector.sv
module pat101_detector
    import pat101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    output logic match_out
);

    det_regs_t  regs_d;
    det_regs_t  regs_q;
    det_state_e step_state;
    logic       step_flag;

    pat101_next i_next (
        .cur_state (regs_q.state),
        .bit_in    (ser_in),
        .nxt_state (step_state)
    );

    pat101_flag i_flag (
        .state_in (step_state),
        .flag_out (step_flag)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d.state = ST_IDLE;
            regs_d.flag  = 1'b0;
        end else begin
            regs_d.state = step_state;
            regs_d.flag  = step_flag;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign match_out = regs_q.flag;

endmodule

// File: rtl/pat101_detector_chk.sv
module pat101_detector_chk
    import pat101_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ser_in,
    input logic       match_out,
    input det_state_e state_q
);

    logic seen_edge;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
    end

    // R1
    r1_reset_idle_chk: assert property (@(posedge clk)
        seen_edge && rst |=> (state_q == ST_IDLE) && !match_out);

    // R2
    r2_idle_step_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |=> state_q == ($past(ser_in) ? ST_ONE : ST_IDLE));

    // R3
    r3_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ONE |=> state_q == ($past(ser_in) ? ST_ONE : ST_ONEZ));

    // R4
    r4_onez_step_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ONEZ |=> state_q == ($past(ser_in) ? ST_MATCH : ST_IDLE));

    // R5
    r5_match_step_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_MATCH |=> state_q == ($past(ser_in) ? ST_ONE : ST_IDLE));

    // R6
    r6_flag_state_chk: assert property (@(posedge clk) disable iff (rst)
        seen_edge |-> match_out == (state_q == ST_MATCH));

    // R8
    r8_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        match_out |=> !match_out);

endmodule

bind pat101_detector pat101_detector_chk i_pat101_detector_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_in    (ser_in),
    .match_out (match_out),
    .state_q   (regs_q.state)
);

// File: tb/test_pat101_detector.sv
module test_pat101_detector;

    localparam time CLK_P   = 10;
    localparam int  N_VEC   = 26;
    localparam int  WD_CYC  = 2000;

    // Each entry: {bit driven, expected match_out after the edge}.
    localparam logic [1:0] VEC [N_VEC] = '{
        2'b10, 2'b00, 2'b11, 2'b00, 2'b10,   // 10101 -> one flag (R7)
        2'b00, 2'b11,                        // seen-one + 0,1 (R3, R4)
        2'b10, 2'b00, 2'b11,                 // 1 after match starts afresh (R5)
        2'b00, 2'b00, 2'b00,                 // match 0 -> idle, idle holds (R5, R2)
        2'b10, 2'b10, 2'b10,                 // seen-one holds on 1 (R3)
        2'b00, 2'b00,                        // seen-one-zero 0 -> idle (R4)
        2'b10, 2'b00, 2'b11,                 // full match from idle (R6)
        2'b00, 2'b10, 2'b00, 2'b11, 2'b00
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic match_out;

    int n_checks = 0;
    int n_fail   = 0;

    pat101_detector i_pat101_detector (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .match_out (match_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (match_out !== exp) begin
            n_fail++;
            $display("FAIL %s: match_out=%b expected=%b at %0t", req, match_out, exp, $time);
        end
    endtask

    // Drive after a falling edge, then sample at the next falling edge.
    task automatic step(input logic b, input logic exp, input string req);
        ser_in = b;
        @(negedge clk);
        check(exp, req);
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state.
        rst = 1'b1;
        ser_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(1'b0, "R1 reset flag");
        rst = 1'b0;

        // R2..R7: table of vectors.
        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i][1], VEC[i][0], "R2 R3 R4 R5 R6 R7 table");
        end

        // R1: reset in seen-one-zero, while a 1 is applied.
        step(1'b1, 1'b0, "R2 prep");
        step(1'b0, 1'b0, "R3 prep");
        rst = 1'b1;
        step(1'b1, 1'b0, "R1 reset beats completing bit");
        rst = 1'b0;
        step(1'b1, 1'b0, "R1 idle after reset");
        step(1'b0, 1'b0, "R1 idle after reset");
        step(1'b1, 1'b1, "R1 clean restart");

        // R1: reset while the flag is high clears it.
        step(1'b0, 1'b0, "R5 prep");
        step(1'b1, 1'b0, "R2 prep");
        step(1'b0, 1'b0, "R3 prep");
        step(1'b1, 1'b1, "R6 flag");
        rst = 1'b1;
        step(1'b0, 1'b0, "R1 flag cleared");
        rst = 1'b0;

        // R8 and R7: a long alternating run gives flags at bits 3, 7, 11 only.
        for (int k = 0; k < 12; k++) begin
            step(~k[0], (k % 4) == 2, "R7 R8 alternating");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule